// File: doc/BRIEF.md
# Page Table Entry Checker

This combinational unit judges one page table entry during address translation. It takes the entry's 8-bit attribute byte, a 10-bit extension field, the kind of access (read, write, read-write or execute), whether the access runs at user privilege, and two status flags. The first flag lets executable pages be read. The second lets supervisor code touch user pages. All results settle in the same cycle as the inputs.

The unit reports four things:
- whether the entry is malformed or not present;
- whether the entry points to the next table level instead of mapping a page;
- whether the access is granted;
- whether the accessed and dirty bits have to be written back, together with the new attribute byte.

A table walker or a TLB refill path uses these results to pick between a fault, a descent to the next level, a write-back of the entry, or a plain hit. The extension field comes back unchanged with every result in 64-bit translation modes. In 32-bit modes it reads as zero.

Attribute byte layout (bit position: meaning): 7 dirty (D), 6 accessed (A), 5 global (G), 4 user (U), 3 execute (X), 2 write (W), 1 read (R), 0 valid (V). Access encoding on `access`: 0 read, 1 write, 2 read-write, 3 execute.

Top module: `pte_checker`

## Requirements
- R1: `is_invalid` is 1 exactly when V (bit 0) is 0, or when W (bit 2) is 1 while R (bit 1) is 0.
- R2: `is_pointer` is 1 exactly when the entry is not invalid and R, W and X (bits 1..3) are all 0. It is never 1 together with `is_invalid`.
- R3: At user privilege (`priv_user`=1), a read (access 0) is granted only when U (bit 4) is 1 and either R is 1, or X is 1 with `mxr`=1.
- R4: At user privilege, a write (access 1) needs U and W. A read-write (access 2) needs U, W and the read condition of R3.
- R5: At user privilege, an execute (access 3) needs U and X.
- R6: At supervisor privilege, a page with U=1 is denied unless `sum`=1 and the access is not an execute. When it is admitted, the R/W/X rules below apply.
- R7: At supervisor privilege, a read needs R, or X with `mxr`=1. A write needs W. A read-write needs both the read and the write condition. An execute needs X.
- R8: `grant` is 0 whenever `is_invalid` or `is_pointer` is 1.
- R9: When access is granted and A (bit 6) is 0, `upd_req` is 1 and `attr_out` has bit 6 set.
- R10: When access is granted, the access is a write or read-write, and D (bit 7) is 0, `upd_req` is 1 and `attr_out` has bits 7 and 6 set. A read or execute never sets D.
- R11: When no bit needs setting, or access is not granted, `upd_req` is 0 and `attr_out` equals `attr_in`. `attr_out` never clears a bit of `attr_in`.
- R12: `ext_out` equals `ext_in` when `wide_mode`=1 and is all zeros when `wide_mode`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| attr_in | input | 8 | Attribute byte of the entry |
| ext_in | input | 10 | Extension field of the entry |
| access | input | 2 | Access kind: 0 read, 1 write, 2 read-write, 3 execute |
| priv_user | input | 1 | 1 for user privilege, 0 for supervisor |
| mxr | input | 1 | Executable pages are also readable |
| sum | input | 1 | Supervisor may access user pages |
| wide_mode | input | 1 | 1 for a 64-bit translation mode |
| is_invalid | output | 1 | Entry is malformed or not present |
| is_pointer | output | 1 | Entry points to the next table level |
| grant | output | 1 | Access is permitted |
| upd_req | output | 1 | Accessed/dirty bits must be written back |
| attr_out | output | 8 | Attribute byte after the update |
| ext_out | output | 10 | Extension field returned with the result |

## Verification
The permission decision and the accessed/dirty update land in the same cycle. An update must follow from a grant and never appear without one. The bench provokes this with writes and read-writes to leaf entries whose A and D are both clear, so both bits must be set in the same result. It then repeats the same attribute byte with privilege, `sum` or U changed so that the grant drops, and expects the update to vanish and the byte to come back untouched. Each result is compared against a model written in the bench as a lookup over access kind and privilege.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

  localparam int ATTR_W = 8;

  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_U = 4;
  localparam int BIT_G = 5;
  localparam int BIT_A = 6;
  localparam int BIT_D = 7;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_RDWR  = 2'd2,
    ACC_EXEC  = 2'd3
  } acc_e;

  // malformed or absent entry
  function automatic logic f_bad_entry(input logic [ATTR_W-1:0] a);
    return !a[BIT_V] || (a[BIT_W] && !a[BIT_R]);
  endfunction

  // no leaf permission at all: next-level pointer
  function automatic logic f_is_link(input logic [ATTR_W-1:0] a);
    return !(a[BIT_R] || a[BIT_W] || a[BIT_X]);
  endfunction

  // R/W/X check independent of privilege
  function automatic logic f_rwx_ok(input acc_e acc, input logic [ATTR_W-1:0] a,
                                    input logic mxr);
    logic rd_ok;
    rd_ok = a[BIT_R] || (a[BIT_X] && mxr);
    case (acc)
      ACC_READ:  return rd_ok;
      ACC_WRITE: return a[BIT_W];
      ACC_RDWR:  return rd_ok && a[BIT_W];
      default:   return a[BIT_X];
    endcase
  endfunction

  function automatic logic f_stores(input acc_e acc);
    return (acc == ACC_WRITE) || (acc == ACC_RDWR);
  endfunction

endpackage

// File: rtl/pte_kind_dec.sv
module pte_kind_dec
  import pte_chk_pkg::*;
(
  input  logic [ATTR_W-1:0] attr,
  output logic              bad,
  output logic              link
);
  always_comb begin
    bad  = f_bad_entry(attr);
    link = f_is_link(attr);
  end
endmodule

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
  import pte_chk_pkg::*;
(
  input  logic [ATTR_W-1:0] attr,
  input  acc_e              acc,
  input  logic              priv_user,
  input  logic              mxr,
  input  logic              sum,
  output logic              perm_ok
);
  logic priv_ok;

  always_comb begin
    if (priv_user)
      priv_ok = attr[BIT_U];
    else if (attr[BIT_U])
      priv_ok = sum && (acc != ACC_EXEC);
    else
      priv_ok = 1'b1;
    perm_ok = priv_ok && f_rwx_ok(acc, attr, mxr);
  end
endmodule

// File: rtl/pte_ad_update.sv
module pte_ad_update
  import pte_chk_pkg::*;
(
  input  logic [ATTR_W-1:0] attr,
  input  acc_e              acc,
  output logic              need_a,
  output logic              need_d,
  output logic [ATTR_W-1:0] attr_new
);
  always_comb begin
    need_a   = !attr[BIT_A];
    need_d   = f_stores(acc) && !attr[BIT_D];
    attr_new = attr;
    if (need_a || need_d) attr_new[BIT_A] = 1'b1;
    if (need_d)           attr_new[BIT_D] = 1'b1;
  end
endmodule

// File: rtl/pte_checker.sv
module pte_checker
  import pte_chk_pkg::*;
#(
  parameter int EXT_W        = 10,
  parameter bit ALLOW_WIDE   = 1'b1
) (
  input  logic [ATTR_W-1:0] attr_in,
  input  logic [EXT_W-1:0]  ext_in,
  input  logic [1:0]        access,
  input  logic              priv_user,
  input  logic              mxr,
  input  logic              sum,
  input  logic              wide_mode,
  output logic              is_invalid,
  output logic              is_pointer,
  output logic              grant,
  output logic              upd_req,
  output logic [ATTR_W-1:0] attr_out,
  output logic [EXT_W-1:0]  ext_out
);
  localparam logic [EXT_W-1:0] EXT_ZERO = '0;

  acc_e              acc;
  logic              ev_bad;
  logic              ev_link;
  logic              ev_perm;
  logic              ev_need_a;
  logic              ev_need_d;
  logic [ATTR_W-1:0] ev_attr_new;

  assign acc = acc_e'(access);

  pte_kind_dec u_kind (
    .attr (attr_in),
    .bad  (ev_bad),
    .link (ev_link)
  );

  pte_perm_eval u_perm (
    .attr      (attr_in),
    .acc       (acc),
    .priv_user (priv_user),
    .mxr       (mxr),
    .sum       (sum),
    .perm_ok   (ev_perm)
  );

  pte_ad_update u_ad (
    .attr     (attr_in),
    .acc      (acc),
    .need_a   (ev_need_a),
    .need_d   (ev_need_d),
    .attr_new (ev_attr_new)
  );

  // invalid beats pointer, pointer beats permission
  always_comb begin
    is_invalid = ev_bad;
    is_pointer = !ev_bad && ev_link;
    grant      = !ev_bad && !ev_link && ev_perm;
    upd_req    = grant && (ev_need_a || ev_need_d);
    attr_out   = upd_req ? ev_attr_new : attr_in;
  end

  generate
    if (ALLOW_WIDE) begin : g_ext_wide
      assign ext_out = wide_mode ? ext_in : EXT_ZERO;
    end else begin : g_ext_narrow
      assign ext_out = EXT_ZERO;
    end
  endgenerate
endmodule

// File: rtl/pte_checker_chk.sv
module pte_checker_chk
  import pte_chk_pkg::*;
#(
  parameter int EXT_W = 10
) (
  input logic [ATTR_W-1:0] attr_in,
  input logic [1:0]        access,
  input logic              priv_user,
  input logic              wide_mode,
  input logic              is_invalid,
  input logic              is_pointer,
  input logic              grant,
  input logic              upd_req,
  input logic [ATTR_W-1:0] attr_out,
  input logic [EXT_W-1:0]  ext_out
);
  logic known;
  assign known = !$isunknown({attr_in, access, priv_user, wide_mode});

  always_comb begin
    if (known) begin
      // R2
      excl_kind_chk: assert (!(is_invalid && is_pointer));
      // R8
      grant_leaf_chk: assert (!grant || (!is_invalid && !is_pointer));
      // R11
      upd_grant_chk: assert (!upd_req || grant);
      // R11
      attr_keep_chk: assert ((attr_out & attr_in) == attr_in);
      // R9
      acc_bit_chk: assert (!upd_req || attr_out[BIT_A]);
      // R10
      no_dirty_read_chk: assert (access[1] != access[0] || attr_out[BIT_D] == attr_in[BIT_D]);
      // R3
      user_page_chk: assert (!(grant && priv_user) || attr_in[BIT_U]);
      // R12
      ext_zero_chk: assert (wide_mode || ext_out == '0);
    end
  end
endmodule

bind pte_checker pte_checker_chk #(.EXT_W(EXT_W)) u_chk (
  .attr_in    (attr_in),
  .access     (access),
  .priv_user  (priv_user),
  .wide_mode  (wide_mode),
  .is_invalid (is_invalid),
  .is_pointer (is_pointer),
  .grant      (grant),
  .upd_req    (upd_req),
  .attr_out   (attr_out),
  .ext_out    (ext_out)
);

// File: tb/pte_checker_test.sv
`timescale 1ns/1ps
module pte_checker_test;
  logic       clk = 1'b0;
  logic [7:0] attr_in;
  logic [9:0] ext_in;
  logic [1:0] access;
  logic       priv_user, mxr, sum, wide_mode;
  logic       is_invalid, is_pointer, grant, upd_req;
  logic [7:0] attr_out;
  logic [9:0] ext_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pte_checker uut (
    .attr_in(attr_in), .ext_in(ext_in), .access(access), .priv_user(priv_user),
    .mxr(mxr), .sum(sum), .wide_mode(wide_mode), .is_invalid(is_invalid),
    .is_pointer(is_pointer), .grant(grant), .upd_req(upd_req),
    .attr_out(attr_out), .ext_out(ext_out)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [1:0] k, input logic u,
                       input logic m, input logic s);
    @(negedge clk);
    attr_in = a; access = k; priv_user = u; mxr = m; sum = s;
    #1;
  endtask

  // independent model: per-kind needed bits
  function automatic logic model_grant(input logic [7:0] a, input logic [1:0] k,
                                       input logic u, input logic m, input logic s);
    logic v, r, w, x, up, readable;
    v = a[0]; r = a[1]; w = a[2]; x = a[3]; up = a[4];
    if (!v || (w && !r)) return 1'b0;
    if ({x, w, r} == 3'b000) return 1'b0;
    if (u && !up) return 1'b0;
    if (!u && up && (!s || k == 2'd3)) return 1'b0;
    readable = r | (x & m);
    case (k)
      2'd0: return readable;
      2'd1: return w;
      2'd2: return readable & w;
      default: return x;
    endcase
  endfunction

  task automatic check_all(input string req);
    logic inv, ptr, g, upd;
    logic [7:0] na;
    inv = (attr_in[0] == 1'b0) || (attr_in[2:1] == 2'b10);
    ptr = !inv && (attr_in[3:1] == 3'b000);
    g   = model_grant(attr_in, access, priv_user, mxr, sum);
    na  = attr_in;
    if (g) begin
      na[6] = 1'b1;
      if (access == 2'd1 || access == 2'd2) na[7] = 1'b1;
    end
    upd = (na != attr_in);
    chk(req, "is_invalid", {15'd0, is_invalid}, {15'd0, inv});
    chk(req, "is_pointer", {15'd0, is_pointer}, {15'd0, ptr});
    chk(req, "grant", {15'd0, grant}, {15'd0, g});
    chk(req, "upd_req", {15'd0, upd_req}, {15'd0, upd});
    chk(req, "attr_out", {8'd0, attr_out}, {8'd0, na});
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    attr_in = 8'h00; ext_in = 10'h000; access = 2'd0;
    priv_user = 0; mxr = 0; sum = 0; wide_mode = 0;
    #1;
    chk("R1", "idle invalid", {15'd0, is_invalid}, 16'd1);
    chk("R8", "idle grant", {15'd0, grant}, 16'd0);
    chk("R12", "idle ext", {6'd0, ext_out}, 16'd0);
  endtask

  task automatic t_kind_sweep(); // R1 R2 R8
    for (int i = 0; i < 256; i++) begin
      apply(i[7:0], 2'd0, 1'b0, 1'b0, 1'b0);
      check_all("R1/R2/R8");
    end
  endtask

  task automatic t_user_modes(); // R3 R4 R5
    for (int a = 0; a < 32; a++)
      for (int k = 0; k < 4; k++)
        for (int m = 0; m < 2; m++) begin
          apply({3'b000, a[4:0]}, k[1:0], 1'b1, m[0], 1'b0);
          check_all(k == 0 ? "R3" : (k == 3 ? "R5" : "R4"));
        end
  endtask

  task automatic t_super_modes(); // R6 R7
    for (int a = 0; a < 32; a++)
      for (int k = 0; k < 4; k++)
        for (int ms = 0; ms < 4; ms++) begin
          apply({3'b000, a[4:0]}, k[1:0], 1'b0, ms[0], ms[1]);
          check_all(a[4] ? "R6" : "R7");
        end
  endtask

  task automatic t_updates(); // R9 R10 R11
    // write to clean untouched user RW page: both bits set together
    apply(8'h17, 2'd1, 1'b1, 1'b0, 1'b0);
    chk("R10", "A+D set", {8'd0, attr_out}, 16'h00D7);
    chk("R10", "upd", {15'd0, upd_req}, 16'd1);
    // same byte, supervisor without sum: no grant, no update
    apply(8'h17, 2'd1, 1'b0, 1'b0, 1'b0);
    chk("R11", "denied upd", {15'd0, upd_req}, 16'd0);
    chk("R11", "denied attr", {8'd0, attr_out}, 16'h0017);
    // read sets only A
    apply(8'h03, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R9", "A only", {8'd0, attr_out}, 16'h0043);
    // A already set, read: nothing
    apply(8'h43, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R11", "no need", {15'd0, upd_req}, 16'd0);
    // A set, D clear, read-write: D (and A) set
    apply(8'h47, 2'd2, 1'b0, 1'b0, 1'b0);
    chk("R10", "D set", {8'd0, attr_out}, 16'h00C7);
    // execute on X page never sets D
    apply(8'h09, 2'd3, 1'b0, 1'b0, 1'b0);
    chk("R10", "exec no D", {8'd0, attr_out}, 16'h0049);
    for (int a = 0; a < 256; a++)
      for (int k = 0; k < 4; k++) begin
        apply(a[7:0], k[1:0], 1'b0, 1'b1, 1'b1);
        check_all("R9/R10/R11");
      end
  endtask

  task automatic t_ext(); // R12
    @(negedge clk);
    ext_in = 10'h2A5; wide_mode = 1'b1; #1;
    chk("R12", "ext wide", {6'd0, ext_out}, 16'h02A5);
    @(negedge clk);
    ext_in = 10'h3FF; #1;
    chk("R12", "ext wide ones", {6'd0, ext_out}, 16'h03FF);
    @(negedge clk);
    wide_mode = 1'b0; #1;
    chk("R12", "ext narrow", {6'd0, ext_out}, 16'h0000);
    apply(8'h17, 2'd1, 1'b1, 1'b0, 1'b0);
    wide_mode = 1'b1; #1;
    chk("R12", "ext with update", {6'd0, ext_out}, 16'h03FF);
  endtask

  initial begin
    t_reset_state();
    t_kind_sweep();
    t_user_modes();
    t_super_modes();
    t_updates();
    t_ext();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule